// File: doc/BRIEF.md
# ARINC 429 Receive Channel

This block receives serial ARINC 429 words on one channel. Its two line inputs come from an external line receiver: one input pulses high for a logic one, the other pulses high for a logic zero, and both low is the null level. The channel makes its own sample strobe from the system clock, at eight samples per bit period, and selects a high or low bit rate. It turns the bit pulses into 32-bit words and treats a long null gap as the end of a word.

Each completed word passes through a few optional stages. Words with the wrong bit count are dropped. The last bit can be replaced by a parity-good flag. A two-bit field can be matched against configured values, and words that do not match are dropped. Words that pass go into a 16-entry receive FIFO, which the host drains through a read strobe. A status flag reports the FIFO condition picked by a 2-bit select code. A sticky overflow output records that a word was lost because the FIFO was full.

An 8-bit control register sets all of these options. It can always be read. It accepts writes only while the channel's owner holds the run input low and the block reports ready.

Top module: `a429_rx_chan`

## Requirements
- R1: Control bit 7 enables reception; any word that completes while it is 0 is not written into the FIFO.
- R2: Control bit 6 selects the sample strobe rate: 0 gives one strobe every HI_DIV clocks and 1 gives one strobe every LO_DIV clocks, with eight strobes per bit period in both cases; a word sent at the selected rate is received intact.
- R3: A strobe that finds exactly one line high after a strobe that found neither or both high starts a bit. It is a one if the one-line is high and a zero if the zero-line is high. The first bit received ends up in data bit 0, and bit n in data bit n-1.
- R4: With control bit 5 at 0, all 32 received bits are stored unchanged.
- R5: With control bit 5 at 1, stored bit 31 is 0 when the 32 received bits hold an odd number of ones and 1 when they hold an even number; bits 30:0 are unchanged.
- R6: With control bit 4 at 1, a word is stored only if its data bit 8 equals control bit 2 and its data bit 9 equals control bit 3; with bit 4 at 0 these bits are not compared.
- R7: A word ends after 32 consecutive null strobes (four bit periods); a word that ends with any bit count other than 32 is discarded.
- R8: The FIFO holds 16 words. A one-cycle high on rd_i while the FIFO is not empty removes the oldest word, which appears on rd_data_o at the next clock edge. A read while the FIFO is empty changes neither rd_data_o nor the FIFO.
- R9: Control bits 1:0 select fifo_flag_o: 00 keeps it 0, 01 sets it while the FIFO is not empty, 10 sets it while the fill level is greater than thresh_i, and 11 sets it while the FIFO holds 16 words.
- R10: A word that completes and is accepted while the FIFO is full is dropped, and overflow_o goes to 1 and stays 1 until reset.
- R11: ready_o is run_i low, registered once. A control write takes effect at the clock edge only when cfg_wr_i is high, run_i is low and ready_o is high; all other writes are ignored.
- R12: cfg_rdata_o shows the control register at all times, including while run_i is high. Reset clears the control register, empties the FIFO, and drives fifo_flag_o and overflow_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_one_i | input | 1 | Line receiver output, high during a one pulse |
| line_zero_i | input | 1 | Line receiver output, high during a zero pulse |
| run_i | input | 1 | High while the channel is in use; blocks control writes |
| ready_o | output | 1 | High when the channel is idle and accepts control writes |
| cfg_wr_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write value |
| cfg_rdata_o | output | 8 | Control register contents |
| thresh_i | input | THR_W | Fill-level threshold for flag code 10 |
| rd_i | input | 1 | FIFO read strobe |
| rd_data_o | output | 32 | Word most recently read from the FIFO |
| fifo_empty_o | output | 1 | FIFO holds no words |
| fifo_flag_o | output | 1 | Programmable FIFO status flag |
| overflow_o | output | 1 | Sticky flag: a word was dropped because the FIFO was full |

## Verification
The hardest case to reach from the ports is the FIFO boundary. A seventeenth accepted word has to arrive on the serial line after sixteen words have fully passed the gap detector, with no read in between. Only then are the drop and the sticky overflow visible, and the sixteen stored words must still read back in order. The bench drives the lines with a pulse generator that can emit any bit count, so it also produces 31-bit and 33-bit frames. A short strobe divisor lets it fill the FIFO word by word, stepping the fill level across the threshold and up to the full mark. Each word's fate is predicted by a queue-based model.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned SMP_PER_BIT = 8;
  localparam int unsigned GAP_BITS    = 4;
  localparam int unsigned CFG_W       = 8;

  // Field order is the register's bit order: enable is bit 7, flag_sel is 1:0.
  typedef struct packed {
    logic       enable;
    logic       slow;
    logic       par_en;
    logic       dec_en;
    logic       match10;
    logic       match9;
    logic [1:0] flag_sel;
  } rx_cfg_t;

  typedef enum logic [1:0] {
    FLAG_OFF      = 2'b00,
    FLAG_NONEMPTY = 2'b01,
    FLAG_ABOVE    = 2'b10,
    FLAG_FULL     = 2'b11
  } flag_sel_e;

endpackage

// File: rtl/a429_rx_cfg.sv
module a429_rx_cfg
  import a429_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output rx_cfg_t          cfg_o,
  output logic             ready_o
);

  rx_cfg_t cfg_q, cfg_d;
  logic    ready_q, ready_d;

  always_comb begin
    ready_d = ~run_i;
    cfg_d   = cfg_q;
    if (wr_i && !run_i && ready_q) begin
      cfg_d = rx_cfg_t'(wdata_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      ready_q <= ready_d;
    end
  end

  assign cfg_o   = cfg_q;
  assign ready_o = ready_q;

  // R11: no write lands while running or not yet ready
  a_r11_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i || !ready_q) |=> $stable(cfg_q));

endmodule

// File: rtl/a429_rx_deser.sv
module a429_rx_deser
  import a429_rx_pkg::*;
#(
  parameter int unsigned HI_DIV      = 156,
  parameter int unsigned LO_DIV      = 1250,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_i,
  input  logic              line_one_i,
  input  logic              line_zero_i,
  output logic              done_o,
  output logic              len_ok_o,
  output logic [WORD_W-1:0] word_o
);

  localparam int unsigned MAX_DIV = (HI_DIV > LO_DIV) ? HI_DIV : LO_DIV;
  localparam int unsigned DIV_W   = $clog2(MAX_DIV + 1);
  localparam int unsigned GAP_SMP = GAP_BITS * SMP_PER_BIT;
  localparam int unsigned GAP_W   = $clog2(GAP_SMP + 1);
  localparam int unsigned BCNT_W  = $clog2(WORD_W + 2);
  localparam logic [BCNT_W-1:0] BCNT_SAT  = BCNT_W'(WORD_W + 1);
  localparam logic [BCNT_W-1:0] BCNT_FULL = BCNT_W'(WORD_W);
  localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(GAP_SMP - 1);
  localparam logic [GAP_W-1:0]  GAP_MAX   = GAP_W'(GAP_SMP);
  localparam logic [DIV_W-1:0]  LIM_HI    = DIV_W'(HI_DIV - 1);
  localparam logic [DIV_W-1:0]  LIM_LO    = DIV_W'(LO_DIV - 1);

  // Input synchronisers
  logic [SYNC_STAGES-1:0] one_sync_q, zero_sync_q;
  logic                   one_s, zero_s;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          one_sync_q  <= '0;
          zero_sync_q <= '0;
        end else begin
          one_sync_q  <= line_one_i;
          zero_sync_q <= line_zero_i;
        end
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          one_sync_q  <= '0;
          zero_sync_q <= '0;
        end else begin
          one_sync_q  <= {one_sync_q[SYNC_STAGES-2:0], line_one_i};
          zero_sync_q <= {zero_sync_q[SYNC_STAGES-2:0], line_zero_i};
        end
      end
    end
  endgenerate

  assign one_s  = one_sync_q[SYNC_STAGES-1];
  assign zero_s = zero_sync_q[SYNC_STAGES-1];

  // Sample strobe divider
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] div_lim;
  logic             tick;

  always_comb begin
    div_lim = slow_i ? LIM_LO : LIM_HI;
    tick    = (div_q >= div_lim);
    div_d   = tick ? '0 : div_q + 1'b1;
  end

  // Bit assembly and gap detection
  logic              act;
  logic              act_q, act_d;
  logic [GAP_W-1:0]  null_q, null_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              done_q, done_d;
  logic              ok_q, ok_d;

  always_comb begin
    act    = one_s ^ zero_s;
    act_d  = act_q;
    null_d = null_q;
    bcnt_d = bcnt_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    ok_d   = ok_q;
    if (tick) begin
      act_d = act;
      if (act) begin
        null_d = '0;
        if (!act_q) begin
          sh_d   = {one_s, sh_q[WORD_W-1:1]};
          bcnt_d = (bcnt_q == BCNT_SAT) ? bcnt_q : bcnt_q + 1'b1;
        end
      end else begin
        if (null_q != GAP_MAX) begin
          null_d = null_q + 1'b1;
        end
        if ((null_q == GAP_LAST) && (bcnt_q != '0)) begin
          done_d = 1'b1;
          ok_d   = (bcnt_q == BCNT_FULL);
          bcnt_d = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      act_q  <= 1'b0;
      null_q <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      div_q  <= div_d;
      act_q  <= act_d;
      null_q <= null_d;
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      ok_q   <= ok_d;
    end
  end

  assign done_o   = done_q;
  assign len_ok_o = ok_q;
  assign word_o   = sh_q;

  // R7: a word end is a single pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: a word end is reported only after the full null gap
  a_r7_done_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!act_q && (null_q == GAP_MAX)));

endmodule

// File: rtl/a429_rx_fifo.sv
module a429_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [W-1:0]               din_i,
  input  logic                       pop_i,
  output logic [W-1:0]               dout_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic                       ovf_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] level_q, level_d;
  logic [W-1:0]     dout_q, dout_d;
  logic             ovf_q, ovf_d;
  logic             full, empty, do_push, do_pop;

  always_comb begin
    full     = (level_q == CNT_FULL);
    empty    = (level_q == '0);
    do_push  = push_i && !full;
    do_pop   = pop_i && !empty;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    dout_d   = dout_q;
    level_d  = level_q;
    ovf_d    = ovf_q | (push_i && full);
    if (do_push) begin
      wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
    end
    if (do_pop) begin
      rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      dout_d   = mem_q[rd_ptr_q];
    end
    case ({do_push, do_pop})
      2'b10:   level_d = level_q + 1'b1;
      2'b01:   level_d = level_q - 1'b1;
      default: level_d = level_q;
    endcase
  end

  // Storage array carries no reset
  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_q[wr_ptr_q] <= din_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      dout_q   <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
      dout_q   <= dout_d;
      ovf_q    <= ovf_d;
    end
  end

  assign dout_o  = dout_q;
  assign empty_o = empty;
  assign full_o  = full;
  assign level_o = level_q;
  assign ovf_o   = ovf_q;

  // R8: fill level never exceeds the depth
  a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= CNT_FULL);

  // R8: a read on an empty FIFO leaves the output word alone
  a_r8_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty) |=> $stable(dout_q));

  // R10: overflow is sticky
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R10: a push into a full FIFO does not raise the level
  a_r10_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !pop_i) |=> (level_q == $past(level_q)));

endmodule

// File: rtl/a429_rx_chan.sv
module a429_rx_chan
  import a429_rx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned THR_W      = 4,
  parameter int unsigned HI_DIV     = 156,
  parameter int unsigned LO_DIV     = 1250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_one_i,
  input  logic              line_zero_i,
  input  logic              run_i,
  output logic              ready_o,
  input  logic              cfg_wr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CFG_W-1:0]  cfg_rdata_o,
  input  logic [THR_W-1:0]  thresh_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              fifo_empty_o,
  output logic              fifo_flag_o,
  output logic              overflow_o
);

  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sn = rst_pipe_q[1];

  rx_cfg_t cfg;

  a429_rx_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_sn),
    .run_i   (run_i),
    .wr_i    (cfg_wr_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .ready_o (ready_o)
  );

  logic              word_done, word_len_ok;
  logic [WORD_W-1:0] word_raw;

  a429_rx_deser #(
    .HI_DIV (HI_DIV),
    .LO_DIV (LO_DIV)
  ) u_deser (
    .clk         (clk),
    .rst_n       (rst_sn),
    .slow_i      (cfg.slow),
    .line_one_i  (line_one_i),
    .line_zero_i (line_zero_i),
    .done_o      (word_done),
    .len_ok_o    (word_len_ok),
    .word_o      (word_raw)
  );

  // Word qualification and parity substitution
  logic              match_ok, push;
  logic [WORD_W-1:0] word_store;

  always_comb begin
    match_ok   = !cfg.dec_en ||
                 ((word_raw[8] == cfg.match9) && (word_raw[9] == cfg.match10));
    push       = word_done && word_len_ok && cfg.enable && match_ok;
    word_store = word_raw;
    if (cfg.par_en) begin
      word_store[WORD_W-1] = ~(^word_raw);
    end
  end

  logic             fifo_full;
  logic [CNT_W-1:0] fifo_level;

  a429_rx_fifo #(
    .DEPTH (FIFO_DEPTH),
    .W     (WORD_W)
  ) u_fifo (
    .clk     (clk),
    .rst_n   (rst_sn),
    .push_i  (push),
    .din_i   (word_store),
    .pop_i   (rd_i),
    .dout_o  (rd_data_o),
    .empty_o (fifo_empty_o),
    .full_o  (fifo_full),
    .level_o (fifo_level),
    .ovf_o   (overflow_o)
  );

  // Status flag select
  always_comb begin
    case (flag_sel_e'(cfg.flag_sel))
      FLAG_NONEMPTY: fifo_flag_o = !fifo_empty_o;
      FLAG_ABOVE:    fifo_flag_o = (32'(fifo_level) > 32'(thresh_i));
      FLAG_FULL:     fifo_flag_o = fifo_full;
      default:       fifo_flag_o = 1'b0;
    endcase
  end

  assign cfg_rdata_o = cfg;

  // R1: while reception is disabled the FIFO never grows
  a_r1_disabled_no_growth: assert property (@(posedge clk) disable iff (!rst_sn)
    !cfg.enable |=> (fifo_level <= $past(fifo_level)));

endmodule

// File: tb/a429_rx_chan_bench.sv
module a429_rx_chan_bench;

  localparam int HI = 2;
  localparam int LO = 16;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        one_l = 1'b0, zero_l = 1'b0;
  logic        run = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [3:0]  thresh = 4'd0;
  logic        ready;
  logic [7:0]  rdata;
  logic [31:0] rd_data;
  logic        empty, flag, ovf;

  always #4 clk = ~clk;

  a429_rx_chan #(
    .FIFO_DEPTH (DEPTH),
    .THR_W      (4),
    .HI_DIV     (HI),
    .LO_DIV     (LO)
  ) u_a429_rx_chan (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_one_i   (one_l),
    .line_zero_i  (zero_l),
    .run_i        (run),
    .ready_o      (ready),
    .cfg_wr_i     (wr),
    .cfg_wdata_i  (wdata),
    .cfg_rdata_o  (rdata),
    .thresh_i     (thresh),
    .rd_i         (rd),
    .rd_data_o    (rd_data),
    .fifo_empty_o (empty),
    .fifo_flag_o  (flag),
    .overflow_o   (ovf)
  );

  int          n_checks = 0;
  int          n_errs = 0;
  logic [31:0] q[$];
  logic [31:0] m_last = 32'h0;
  logic [7:0]  m_cfg;
  logic        m_ready;
  logic        m_ovf = 1'b0;
  bit          settled = 1'b1;
  bit          cmp_on = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: control register and ready (R11, R12)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg   <= 8'h00;
      m_ready <= 1'b0;
    end else begin
      if (wr && !run && m_ready) m_cfg <= wdata;
      m_ready <= !run;
    end
  end

  function automatic logic m_flag();
    case (m_cfg[1:0])
      2'b01:   return q.size() != 0;
      2'b10:   return q.size() > int'(thresh);
      2'b11:   return q.size() == DEPTH;
      default: return 1'b0;
    endcase
  endfunction

  // Compare on every clock
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R12 cfg readback", {24'h0, rdata}, {24'h0, m_cfg});
      chk("R11 ready", {31'h0, ready}, {31'h0, m_ready});
      if (settled) begin
        chk("R8 empty", {31'h0, empty}, {31'h0, (q.size() == 0)});
        chk("R9 flag", {31'h0, flag}, {31'h0, m_flag()});
        chk("R10 overflow", {31'h0, ovf}, {31'h0, m_ovf});
      end
    end
  end

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    wr = 1'b1; wdata = v;
    step(1);
    wr = 1'b0;
    step(1);
  endtask

  // Drive a frame of n bits, first bit = bits[0], then wait out the gap
  task automatic send(input logic [63:0] bits, input int n, input bit slow);
    int div;
    logic [31:0] w;
    div = slow ? LO : HI;
    settled = 1'b0;
    for (int i = 0; i < n; i++) begin
      one_l = bits[i]; zero_l = !bits[i];
      step(4 * div);
      one_l = 1'b0; zero_l = 1'b0;
      step(4 * div);
    end
    step(4 * 8 * div + 24);
    w = bits[31:0];
    if (n == 32 && m_cfg[7] && (!m_cfg[4] || (w[8] == m_cfg[2] && w[9] == m_cfg[3]))) begin
      if (m_cfg[5]) w[31] = ~(^bits[31:0]);
      if (q.size() < DEPTH) q.push_back(w);
      else m_ovf = 1'b1;
    end
    settled = 1'b1;
    step(1);
  endtask

  task automatic rd_word(input string req);
    rd = 1'b1;
    step(1);
    rd = 1'b0;
    if (q.size() != 0) m_last = q.pop_front();
    @(negedge clk);
    chk(req, rd_data, m_last);
    step(1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(6);
    cmp_on = 1'b1;

    // R12: reset state
    chk("R12 reset cfg", {24'h0, rdata}, 32'h0);
    chk("R12 reset empty", {31'h0, empty}, 32'h1);
    chk("R12 reset flag", {31'h0, flag}, 32'h0);
    chk("R12 reset overflow", {31'h0, ovf}, 32'h0);

    // R1: disabled channel stores nothing
    send(64'h0000_0000_1122_3344, 32, 1'b0);
    chk("R1 disabled no store", {31'h0, empty}, 32'h1);

    // R11: writes while running or not yet ready are ignored
    run = 1'b1; step(2);
    wr_cfg(8'h81);
    chk("R11 write while run", {24'h0, rdata}, 32'h0);
    chk("R12 read while run", {24'h0, rdata}, {24'h0, m_cfg});
    run = 1'b0; wr = 1'b1; wdata = 8'h81;
    step(1);
    wr = 1'b0;
    chk("R11 write before ready", {24'h0, rdata}, 32'h0);
    step(1);
    wr_cfg(8'h81);
    chk("R11 write when idle", {24'h0, rdata}, 32'h81);

    // R3 R4: raw word, bit order
    send(64'h0000_0000_1234_5677, 32, 1'b0);
    chk("R9 nonempty flag", {31'h0, flag}, 32'h1);
    rd_word("R3 R4 raw word");
    send(64'h0000_0000_8000_0001, 32, 1'b0);
    rd_word("R3 first bit in bit 0");

    // R5: parity substitution
    wr_cfg(8'hA0);
    send(64'h0000_0000_8000_0000, 32, 1'b0);
    rd_word("R5 odd parity flag 0");
    chk("R5 odd value", rd_data, 32'h0000_0000);
    send(64'h0000_0000_0000_0003, 32, 1'b0);
    rd_word("R5 even parity flag 1");
    chk("R5 even value", rd_data, 32'h8000_0003);

    // R6: field match on data bits 9:8 (ctrl bit3 -> bit9, bit2 -> bit8)
    wr_cfg(8'h98);
    send(64'h0000_0000_0000_0200, 32, 1'b0);
    send(64'h0000_0000_0000_0100, 32, 1'b0);
    send(64'h0000_0000_0000_0300, 32, 1'b0);
    chk("R6 only match kept", q.size(), 32'd1);
    rd_word("R6 matching word");
    chk("R6 drain empty", {31'h0, empty}, 32'h1);

    // R2: low rate
    wr_cfg(8'hC1);
    send(64'h0000_0000_A5A5_0F0F, 32, 1'b1);
    chk("R2 slow word stored", {31'h0, empty}, 32'h0);
    rd_word("R2 slow word value");

    // R7: framing errors
    wr_cfg(8'h81);
    send(64'h0000_0000_7FFF_FFFF, 31, 1'b0);
    chk("R7 short frame dropped", {31'h0, empty}, 32'h1);
    send(64'h0000_0001_5555_5555, 33, 1'b0);
    chk("R7 long frame dropped", {31'h0, empty}, 32'h1);
    send(64'h0000_0000_CAFE_F00D, 32, 1'b0);
    rd_word("R7 recovery after framing");

    // R9: threshold mode and off mode
    thresh = 4'd3;
    wr_cfg(8'h82);
    for (int i = 0; i < 3; i++) send(64'(32'h100 + i), 32, 1'b0);
    chk("R9 level 3 not above 3", {31'h0, flag}, 32'h0);
    send(64'h0000_0000_0000_0AAA, 32, 1'b0);
    chk("R9 level 4 above 3", {31'h0, flag}, 32'h1);
    thresh = 4'd4; step(1);
    chk("R9 threshold raised", {31'h0, flag}, 32'h0);
    wr_cfg(8'h80);
    chk("R9 off mode", {31'h0, flag}, 32'h0);

    // R9 R10: fill to full, then overflow
    wr_cfg(8'h83);
    for (int i = 4; i < DEPTH; i++) send(64'(32'h200 + i), 32, 1'b0);
    chk("R9 full flag", {31'h0, flag}, 32'h1);
    chk("R10 no overflow yet", {31'h0, ovf}, 32'h0);
    send(64'h0000_0000_DEAD_BEEF, 32, 1'b0);
    chk("R10 overflow set", {31'h0, ovf}, 32'h1);
    for (int i = 0; i < DEPTH; i++) rd_word("R8 R10 drain order");
    chk("R10 overflow sticky", {31'h0, ovf}, 32'h1);
    rd_word("R8 empty read holds");
    chk("R8 empty read value", rd_data, 32'h0000_020F);

    step(4);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

endmodule